// File: doc/BRIEF.md
# Sprite Attribute Table Copy Engine

This block copies a fixed run of 160 bytes from the system address space into the sprite attribute RAM, one byte at a time. A single strobe carrying a 16-bit base address starts a run. After a fixed start latency the engine reads the system bus at the current source address and writes the byte into sprite RAM one cycle later. The source address and the sprite RAM index then step forward by one, and the next byte follows a fixed number of cycles later.

While a run is in progress the engine raises a busy flag and shows the address of the next byte it will fetch. A bus decoder elsewhere uses these two outputs to detect conflicts between processor accesses and the copy. A strobe whose base lies above the last legal page start is dropped without any effect. A legal strobe that arrives during a run abandons the remaining bytes and starts over from the new base, with the full start latency again.

Top module: `sprite_dma`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `rd_req_o` and `oam_we_o` are all low.
- R2: A strobe whose `base_i` is greater than 0xF100 has no effect. This holds when the engine is idle (busy stays low and no read follows) and during a run (the run keeps its schedule and its addresses). A base of exactly 0xF100 is accepted.
- R3: In the cycle after an accepted strobe, `busy_o` is high and `src_addr_o` equals the strobe's base.
- R4: If an accepted strobe is high in cycle c, the first read (`rd_req_o` high, `rd_addr_o` = base) occurs in cycle c+8.
- R5: Each later read comes exactly 4 cycles after the previous one, at the previous address plus one. A run makes exactly 160 reads, so the last read falls in cycle c+8+159*4 = c+644.
- R6: In the cycle after each read, `oam_we_o` is high, `oam_addr_o` holds the byte's index in the run (0 for the first byte, up to 159), and `oam_wdata_o` holds the `rd_data_i` value presented during the read cycle. `rd_data_i` must be valid in the same cycle as `rd_req_o`.
- R7: `busy_o` stays high up to and including the cycle of the last sprite RAM write (c+645) and is low from c+646. While `busy_o` is low there are no reads and no writes.
- R8: An accepted strobe during a run restarts it from the new base at index 0 with the 8-cycle latency. A read that would have fallen in the strobe's own cycle is dropped. A write whose read already happened still completes in the following cycle.
- R9: `src_addr_o` is always the address of the next byte to fetch: after k reads of a run it equals base+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start strobe |
| base_i | input | 16 | Source base address sampled with the strobe |
| rd_req_o | output | 1 | System bus read request for this cycle |
| rd_addr_o | output | 16 | System bus read address |
| rd_data_i | input | 8 | Read data, valid in the request cycle |
| oam_we_o | output | 1 | Sprite RAM write enable |
| oam_addr_o | output | 8 | Sprite RAM byte index |
| oam_wdata_o | output | 8 | Sprite RAM write data |
| busy_o | output | 1 | Copy in progress, for the bus decoder |
| src_addr_o | output | 16 | Address of the next byte to fetch |

## Verification
On every cycle the assertions check the local relations between cycles. An accepted strobe raises busy and loads the source address on the next cycle. Every read is followed by a write carrying its data, reads never come in consecutive cycles, the source address moves by exactly one per read, and nothing moves while busy is low. Only the bench scenarios can show the long-range timing: the 8-cycle first delay, the 4-cycle spacing over 160 bytes, the total duration, and the final contents of sprite RAM. They also show the restart behaviour: which queued bytes are dropped when a new strobe lands exactly on a read cycle or between two reads, and that an oversized base leaves a running copy untouched.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } dma_phase_e;

    localparam int unsigned DEF_ADDR_W      = 16;
    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_XFER_LEN    = 160;
    localparam int unsigned DEF_FIRST_DELAY = 8;
    localparam int unsigned DEF_STEP_DELAY  = 4;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sprite_dma_pacer.sv
module sprite_dma_pacer
    import sprite_dma_pkg::*;
#(
    parameter int unsigned FIRST_DELAY = DEF_FIRST_DELAY,
    parameter int unsigned STEP_DELAY  = DEF_STEP_DELAY
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch_i,
    input  logic       last_i,
    output logic       step_o,
    output dma_phase_e phase_o
);

    localparam int unsigned MAX_DLY = max_u(FIRST_DELAY, STEP_DELAY);
    localparam int unsigned TICK_W  = $clog2(MAX_DLY) + 1;
    localparam logic [TICK_W-1:0] FIRST_LOAD = TICK_W'(FIRST_DELAY - 1);
    localparam logic [TICK_W-1:0] STEP_LOAD  = TICK_W'(STEP_DELAY - 1);

    typedef struct packed {
        dma_phase_e        phase;
        logic [TICK_W-1:0] tick;
    } pacer_t;

    pacer_t pac_d, pac_q;
    logic   step_d;

    always_comb begin
        pac_d  = pac_q;
        step_d = (pac_q.phase == PH_RUN) && (pac_q.tick == '0) && !launch_i;
        if (launch_i) begin
            pac_d.phase = PH_RUN;
            pac_d.tick  = FIRST_LOAD;
        end else if (step_d) begin
            if (last_i) begin
                pac_d.phase = PH_IDLE;
                pac_d.tick  = '0;
            end else begin
                pac_d.tick  = STEP_LOAD;
            end
        end else if (pac_q.phase == PH_RUN) begin
            pac_d.tick = pac_q.tick - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pac_q <= '{phase: PH_IDLE, tick: '0};
        end else begin
            pac_q <= pac_d;
        end
    end

    assign step_o  = step_d;
    assign phase_o = pac_q.phase;

    // R5
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R1
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pac_q.phase == PH_IDLE) |-> (pac_q.tick == '0) && !step_o);

endmodule

// File: rtl/sprite_dma_cursor.sv
module sprite_dma_cursor
    import sprite_dma_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned XFER_LEN = DEF_XFER_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] src_o,
    output logic [$clog2(XFER_LEN)-1:0] idx_o,
    output logic              last_o
);

    localparam int unsigned IDX_W = $clog2(XFER_LEN);
    localparam int unsigned CNT_W = $clog2(XFER_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(XFER_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  left;
    } cursor_t;

    cursor_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (launch_i) begin
            cur_d.src  = base_i;
            cur_d.idx  = '0;
            cur_d.left = CNT_FULL;
        end else if (step_i) begin
            cur_d.src  = cur_q.src + 1'b1;
            cur_d.idx  = cur_q.idx + 1'b1;
            cur_d.left = cur_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{src: '0, idx: '0, left: '0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign src_o  = cur_q.src;
    assign idx_o  = cur_q.idx;
    assign last_o = (cur_q.left == CNT_W'(1));

    // R5
    left_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.left <= CNT_FULL);

    // R5
    step_has_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cur_q.left != '0));

endmodule

// File: rtl/sprite_dma_writer.sv
module sprite_dma_writer
    import sprite_dma_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              we_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              pend;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wstage_t;

    wstage_t ws_d, ws_q;

    always_comb begin
        ws_d      = ws_q;
        ws_d.pend = step_i;
        if (step_i) begin
            ws_d.idx  = idx_i;
            ws_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q <= '{pend: 1'b0, idx: '0, data: '0};
        end else begin
            ws_q <= ws_d;
        end
    end

    assign we_o   = ws_q.pend;
    assign idx_o  = ws_q.idx;
    assign data_o = ws_q.data;

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
    import sprite_dma_pkg::*;
#(
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned XFER_LEN    = DEF_XFER_LEN,
    parameter int unsigned FIRST_DELAY = DEF_FIRST_DELAY,
    parameter int unsigned STEP_DELAY  = DEF_STEP_DELAY,
    parameter logic [15:0] BASE_LIMIT  = 16'hF100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [15:0] base_i,
    output logic        rd_req_o,
    output logic [15:0] rd_addr_o,
    input  logic [7:0]  rd_data_i,
    output logic        oam_we_o,
    output logic [7:0]  oam_addr_o,
    output logic [7:0]  oam_wdata_o,
    output logic        busy_o,
    output logic [15:0] src_addr_o
);

    localparam int unsigned IDX_W = $clog2(XFER_LEN);

    logic              launch;
    logic              step;
    logic              last;
    dma_phase_e        phase;
    logic [ADDR_W-1:0] src;
    logic [IDX_W-1:0]  idx;
    logic              wr_pend;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;

    assign launch = start_i && (base_i <= BASE_LIMIT);

    sprite_dma_pacer #(
        .FIRST_DELAY (FIRST_DELAY),
        .STEP_DELAY  (STEP_DELAY)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .last_i   (last),
        .step_o   (step),
        .phase_o  (phase)
    );

    sprite_dma_cursor #(
        .ADDR_W   (ADDR_W),
        .XFER_LEN (XFER_LEN)
    ) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .base_i   (ADDR_W'(base_i)),
        .step_i   (step),
        .src_o    (src),
        .idx_o    (idx),
        .last_o   (last)
    );

    sprite_dma_writer #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_writer (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .idx_i  (idx),
        .data_i (DATA_W'(rd_data_i)),
        .we_o   (wr_pend),
        .idx_o  (wr_idx),
        .data_o (wr_data)
    );

    assign rd_req_o    = step;
    assign rd_addr_o   = 16'(src);
    assign src_addr_o  = 16'(src);
    assign oam_we_o    = wr_pend;
    assign oam_addr_o  = 8'(wr_idx);
    assign oam_wdata_o = 8'(wr_data);
    assign busy_o      = (phase == PH_RUN) || wr_pend;

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (base_i <= BASE_LIMIT)) |=> busy_o && (src_addr_o == $past(base_i)));

    // R2
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (base_i > BASE_LIMIT) && !busy_o) |=> !busy_o);

    // R6
    write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> oam_we_o && (oam_wdata_o == $past(rd_data_i)));

    // R7
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o && !oam_we_o);

    // R8
    launch_drops_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (base_i <= BASE_LIMIT)) |-> !rd_req_o);

    // R9
    src_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> (src_addr_o == $past(src_addr_o) + 16'd1));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !rd_req_o && !oam_we_o);

endmodule

// File: tb/tb_sprite_dma.sv
module tb_sprite_dma;

    typedef struct {
        int          cyc;
        logic [15:0] addr;
    } rd_item_t;

    typedef struct {
        int         cyc;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] base_i = '0;
    logic        rd_req_o;
    logic [15:0] rd_addr_o;
    logic [7:0]  rd_data_i;
    logic        oam_we_o;
    logic [7:0]  oam_addr_o;
    logic [7:0]  oam_wdata_o;
    logic        busy_o;
    logic [15:0] src_addr_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    rd_item_t   rdq[$];
    wr_item_t   wrq[$];
    logic [7:0] oam_model [160];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return (a[7:0] * 8'd3 + a[15:8]) ^ 8'hA5;
    endfunction

    assign rd_data_i = pattern(rd_addr_o);

    sprite_dma dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_i      (base_i),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .rd_data_i   (rd_data_i),
        .oam_we_o    (oam_we_o),
        .oam_addr_o  (oam_addr_o),
        .oam_wdata_o (oam_wdata_o),
        .busy_o      (busy_o),
        .src_addr_o  (src_addr_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d",
                     req, act, act, exp, exp, cyc);
        end
    endtask

    // Monitor: pops expected reads and writes as the design produces them.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_req_o) begin
                if (rdq.size() == 0) begin
                    check(1'b0, "R5 unexpected read", rd_addr_o, -1);
                end else begin
                    rd_item_t r;
                    r = rdq.pop_front();
                    check(cyc == r.cyc, "R4/R5 read cycle", cyc, r.cyc);
                    check(rd_addr_o == r.addr, "R5 read address", rd_addr_o, r.addr);
                    check(src_addr_o == r.addr, "R9 source output", src_addr_o, r.addr);
                end
            end
            if (rst_n && oam_we_o) begin
                if (wrq.size() == 0) begin
                    check(1'b0, "R6 unexpected write", oam_addr_o, -1);
                end else begin
                    wr_item_t w;
                    w = wrq.pop_front();
                    check(cyc == w.cyc, "R6 write cycle", cyc, w.cyc);
                    check(oam_addr_o == w.idx, "R6 write index", oam_addr_o, w.idx);
                    check(oam_wdata_o == w.data, "R6 write data", oam_wdata_o, w.data);
                end
                if (oam_addr_o < 8'd160) oam_model[oam_addr_o] = oam_wdata_o;
            end
            if (rst_n && !busy_o && (rd_req_o || oam_we_o)) begin
                check(1'b0, "R7 activity while idle", 1, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver: call in a cycle after posedge+5; strobe is high for this cycle.
    task automatic launch(input logic [15:0] b, output int c);
        c       = cyc;
        start_i = 1'b1;
        base_i  = b;
        if (b <= 16'hF100) begin
            for (int i = rdq.size() - 1; i >= 0; i--)
                if (rdq[i].cyc >= c) rdq.delete(i);
            for (int i = wrq.size() - 1; i >= 0; i--)
                if (wrq[i].cyc > c) wrq.delete(i);
            for (int i = 0; i < 160; i++) begin
                rd_item_t r;
                wr_item_t w;
                logic [15:0] a;
                a = b + 16'(i);
                r.cyc  = c + 8 + 4 * i;
                r.addr = a;
                w.cyc  = r.cyc + 1;
                w.idx  = 8'(i);
                w.data = pattern(a);
                rdq.push_back(r);
                wrq.push_back(w);
            end
        end
        @(posedge clk); #5;
        start_i = 1'b0;
    endtask

    task automatic go_to(input int target);
        while (cyc < target) begin
            @(posedge clk); #5;
        end
    endtask

    task automatic wait_idle(output int t);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        t = cyc;
    endtask

    task automatic check_oam(input logic [15:0] b, input string req);
        for (int i = 0; i < 160; i++)
            check(oam_model[i] == pattern(b + 16'(i)), req, oam_model[i], pattern(b + 16'(i)));
    endtask

    task automatic full_run(input logic [15:0] b);
        int c, t;
        for (int i = 0; i < 160; i++) oam_model[i] = 8'h00;
        launch(b, c);
        @(negedge clk);
        // R3: busy and source visible in the cycle after the strobe
        check(busy_o == 1'b1, "R3 busy after start", busy_o, 1);
        check(src_addr_o == b, "R3 source after start", src_addr_o, b);
        wait_idle(t);
        // R7: busy low from c+646; R5: all reads consumed by c+644
        check(t == c + 646, "R7 busy fall cycle", t - c, 646);
        check(rdq.size() == 0, "R5 read count", rdq.size(), 0);
        check(wrq.size() == 0, "R6 write count", wrq.size(), 0);
        check(src_addr_o == b + 16'd160, "R9 source after run", src_addr_o, b + 16'd160);
        check_oam(b, "R6 sprite RAM content");
        @(posedge clk); #5;
    endtask

    initial begin
        int c, t;
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        check(!busy_o && !rd_req_o && !oam_we_o, "R1 outputs in reset", busy_o, 0);
        rst_n = 1'b1;
        @(posedge clk); #5;
        check(!busy_o && !rd_req_o && !oam_we_o, "R1 outputs after reset", busy_o, 0);

        // R2: oversized bases while idle
        launch(16'hF101, c);
        launch(16'hFFFF, c);
        repeat (12) begin
            @(negedge clk);
            check(!busy_o, "R2 reject while idle", busy_o, 0);
        end
        @(posedge clk); #5;

        // R4 R5 R6 R7 R9: full run from a work RAM page
        full_run(16'hC000);
        // R2: boundary base 0xF100 accepted
        full_run(16'hF100);

        // R8: restart landing exactly on a read cycle, then an ignored strobe
        for (int i = 0; i < 160; i++) oam_model[i] = 8'h00;
        launch(16'h8000, c);
        go_to(c + 8 + 4 * 10);
        launch(16'hD230, c);
        go_to(c + 8 + 4 * 5 + 2);
        // R2: oversized strobe mid-run changes nothing
        launch(16'hF200, t);
        wait_idle(t);
        check(t == c + 646, "R8 busy fall after restart", t - c, 646);
        check(rdq.size() == 0 && wrq.size() == 0, "R8 queues drained", rdq.size() + wrq.size(), 0);
        check_oam(16'hD230, "R8 content after restart");
        @(posedge clk); #5;

        // R8: restart between two reads
        launch(16'h0100, c);
        go_to(c + 8 + 4 * 3 + 2);
        launch(16'h4321, c);
        wait_idle(t);
        check(t == c + 646, "R8 busy fall mid-gap restart", t - c, 646);
        check(rdq.size() == 0 && wrq.size() == 0, "R8 queues drained", rdq.size() + wrq.size(), 0);
        check_oam(16'h4321, "R8 content mid-gap restart");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule